// File: doc/BRIEF.md
# Stack-Register Multiply/Divide Step Unit

This unit is the arithmetic helper of a 16-bit stack processor. It operates on the three top stack registers, called top (T), next (N) and third (N2). It knows two single-cycle step operations. The multiply step adds N2 into T when the low bit of N is set, then shifts the T:N pair right by one. The divide step shifts the T:N pair left by one and subtracts N2 from the upper part when the divisor fits, recording a quotient bit in N.

A built-in sequencer repeats one chosen step sixteen times after a start strobe. This yields an unsigned 16x16 to 32 product (high word in T, low word in N) or an unsigned 32/16 division (remainder in T, quotient in N). A single-step mode applies exactly one step per strobe, so that firmware can write the loop itself. A divide whose quotient cannot fit in 16 bits raises an overflow flag.

Top module: `stk_muldiv`

## Requirements
- R1: After reset, t_out and n_out are 0, and busy, done and ovf are all low.
- R2: A single-mode multiply step (op_code 5'b11110) gives S = {0,t_in} + {0,n2_in} when n_in[0] is 1, and S = {0,t_in} otherwise. T becomes S[16:1] and N becomes {S[0], n_in[15:1]}.
- R3: A single-mode divide step (op_code 5'b11111) forms V = {t_in, n_in[15]}. If V >= n2_in, T becomes (V - n2_in)[15:0] and N becomes {n_in[14:0],1}. Otherwise T becomes V[15:0] and N becomes {n_in[14:0],0}.
- R4: A sequenced multiply ignores t_in, starts with T = 0, and after 16 steps leaves the high product word of n_in*n2_in in T and the low word in N.
- R5: A sequenced divide with t_in < n2_in leaves ({t_in,n_in} mod n2_in) in T and ({t_in,n_in} / n2_in) in N after 16 steps.
- R6: After an accepted sequenced start, busy is high for exactly 16 cycles. done is high for exactly one cycle, the cycle after busy falls, and it is never high together with busy.
- R7: ovf is set by an accepted divide start whose n2_in <= t_in and cleared by any other accepted start. It holds its value until the next accepted start.
- R8: A start while busy is ignored: the running operation's result and busy length are unchanged.
- R9: A start whose op_code is neither 5'b11110 nor 5'b11111 is ignored: T, N, busy and done stay unchanged.
- R10: In single mode, each accepted strobe applies exactly one step, busy stays low, and done pulses for one cycle in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe that launches an operation |
| single | input | 1 | 1: apply one step per strobe; 0: run 16 steps |
| op_code | input | 5 | Step select: 5'b11110 multiply, 5'b11111 divide |
| t_in | input | 16 | Top-of-stack value |
| n_in | input | 16 | Next-of-stack value |
| n2_in | input | 16 | Third stack value (multiplicand or divisor) |
| t_out | output | 16 | Registered T |
| n_out | output | 16 | Registered N |
| busy | output | 1 | Sequenced run in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Divide quotient overflow |

## Verification
The assertions assume that operand ports only matter in the cycle where a start is accepted, and that a start is only ever accepted while the unit is idle. They also assume that the divisor register stays fixed for a whole run. The stimulus changes operands and strobes only on the falling edge. It raises start for a single cycle, and during runs it only issues strobes that the unit must reject. Quotient and remainder checks use only divides where the high numerator word is below the divisor. Overflow cases are checked only through the flag.

// File: rtl/stk_muldiv_pkg.sv
package stk_muldiv_pkg;
    localparam int OPW = 5;
    localparam logic [OPW-1:0] OPC_MUL = 5'b11110;
    localparam logic [OPW-1:0] OPC_DIV = 5'b11111;
endpackage

// File: rtl/stk_muldiv_step.sv
module stk_muldiv_step #(
    parameter int W = 16
) (
    input  logic         is_div,
    input  logic [W-1:0] t_i,
    input  logic [W-1:0] n_i,
    input  logic [W-1:0] n2_i,
    output logic [W-1:0] t_o,
    output logic [W-1:0] n_o
);
    localparam int XW = W + 1;

    logic [XW-1:0] mul_sum;
    logic [XW-1:0] div_win;
    logic [XW-1:0] div_rem;
    logic          div_fit;

    always_comb begin
        // multiply: conditional add then shift T:N right
        mul_sum = n_i[0] ? ({1'b0, t_i} + {1'b0, n2_i}) : {1'b0, t_i};
        // divide: shift T:N left, trial subtract divisor
        div_win = {t_i, n_i[W-1]};
        div_fit = (div_win >= {1'b0, n2_i});
        div_rem = div_fit ? (div_win - {1'b0, n2_i}) : div_win;
        if (is_div) begin
            t_o = div_rem[W-1:0];
            n_o = {n_i[W-2:0], div_fit};
        end else begin
            t_o = mul_sum[XW-1:1];
            n_o = {mul_sum[0], n_i[W-1:1]};
        end
    end
endmodule

// File: rtl/stk_muldiv_seq.sv
module stk_muldiv_seq #(
    parameter int STEPS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic last
);
    localparam int CW = $clog2(STEPS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (launch && cnt_q == '0) begin
            cnt_d = CW'(STEPS);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == CW'(1));

    // R6: count never exceeds the step total
    a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(STEPS));
    // R8: a running count only moves down by one, whatever launch does
    a_r8_cnt_steady: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/stk_muldiv.sv
module stk_muldiv
    import stk_muldiv_pkg::*;
#(
    parameter int W     = 16,
    parameter int STEPS = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           single,
    input  logic [OPW-1:0] op_code,
    input  logic [W-1:0]   t_in,
    input  logic [W-1:0]   n_in,
    input  logic [W-1:0]   n2_in,
    output logic [W-1:0]   t_out,
    output logic [W-1:0]   n_out,
    output logic           busy,
    output logic           done,
    output logic           ovf
);
    typedef struct packed {
        logic [W-1:0] t;
        logic [W-1:0] n;
        logic [W-1:0] n2;
        logic         div;
        logic         done;
        logic         ovf;
    } st_t;

    st_t st_d, st_q;

    logic         seq_busy, seq_last;
    logic         op_ok, op_div, accept;
    logic         stp_div;
    logic [W-1:0] stp_t, stp_n, stp_n2;
    logic [W-1:0] res_t, res_n;

    always_comb begin
        op_div  = (op_code == OPC_DIV);
        op_ok   = (op_code == OPC_MUL) || op_div;
        accept  = start && !seq_busy && op_ok;
        if (accept && single) begin
            stp_div = op_div;
            stp_t   = t_in;
            stp_n   = n_in;
            stp_n2  = n2_in;
        end else begin
            stp_div = st_q.div;
            stp_t   = st_q.t;
            stp_n   = st_q.n;
            stp_n2  = st_q.n2;
        end
    end

    stk_muldiv_step #(.W(W)) u_step (
        .is_div (stp_div),
        .t_i    (stp_t),
        .n_i    (stp_n),
        .n2_i   (stp_n2),
        .t_o    (res_t),
        .n_o    (res_n)
    );

    stk_muldiv_seq #(.STEPS(STEPS)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (accept && !single),
        .busy   (seq_busy),
        .last   (seq_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.div = op_div;
            st_d.ovf = op_div && (n2_in <= t_in);
            st_d.n2  = n2_in;
            if (single) begin
                st_d.t    = res_t;
                st_d.n    = res_n;
                st_d.done = 1'b1;
            end else begin
                st_d.t = op_div ? t_in : '0;
                st_d.n = n_in;
            end
        end else if (seq_busy) begin
            st_d.t = res_t;
            st_d.n = res_n;
            if (seq_last) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign t_out = st_q.t;
    assign n_out = st_q.n;
    assign busy  = seq_busy;
    assign done  = st_q.done;
    assign ovf   = st_q.ovf;

    // R6: completion pulse follows the end of a run
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R6: done and busy never overlap
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    // R7: overflow flag only changes on an accepted start
    a_r7_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(ovf));
    // R4/R5: divisor/multiplicand register fixed during a run
    a_r5_n2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !accept) |=> $stable(st_q.n2));
    // R10: a single step completes next cycle without going busy
    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && single) |=> (done && !busy));
endmodule

// File: tb/stk_muldiv_bench.sv
module stk_muldiv_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         single = 1'b0;
    logic [4:0]   op_code = '0;
    logic [W-1:0] t_in = '0, n_in = '0, n2_in = '0;
    logic [W-1:0] t_out, n_out;
    logic         busy, done, ovf;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    stk_muldiv u_stk_muldiv (
        .clk(clk), .rst_n(rst_n), .start(start), .single(single),
        .op_code(op_code), .t_in(t_in), .n_in(n_in), .n2_in(n2_in),
        .t_out(t_out), .n_out(n_out), .busy(busy), .done(done), .ovf(ovf)
    );

    // {is_div, t_in, n_in, n2_in}
    localparam int NV = 8;
    localparam logic [48:0] VEC [NV] = '{
        {1'b0, 16'hBEEF, 16'd11,   16'd13},
        {1'b0, 16'h1111, 16'hFFFF, 16'hFFFF},
        {1'b0, 16'h0000, 16'h0000, 16'h1234},
        {1'b0, 16'hFFFF, 16'h5678, 16'h1234},
        {1'b1, 16'h0000, 16'd135,  16'd13},
        {1'b1, 16'h0001, 16'h0000, 16'h0002},
        {1'b1, 16'h7FFF, 16'hFFFF, 16'hFFFF},
        {1'b1, 16'h0000, 16'hABCD, 16'h0001}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic launch(input logic dv, input logic sg,
                          input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        @(negedge clk);
        op_code = dv ? 5'b11111 : 5'b11110;
        single = sg; t_in = a; n_in = b; n2_in = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(output int cyc);
        cyc = 0;
        while (busy && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R6 got=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] num, prod;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 t", t_out, 0); chk("R1 n", n_out, 0);
        chk("R1 flags", {busy, done, ovf}, 0);
        rst_n = 1'b1;

        // table: R4 multiply, R5 divide, R6 timing
        for (int i = 0; i < NV; i++) begin
            launch(VEC[i][48], 1'b0, VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
            wait_end(cyc);
            chk("R6 busy len", cyc, 16);
            chk("R6 done", done, 1);
            if (VEC[i][48]) begin
                num = {VEC[i][47:32], VEC[i][31:16]};
                chk("R5 rem", t_out, num % VEC[i][15:0]);
                chk("R5 quot", n_out, num / VEC[i][15:0]);
            end else begin
                prod = VEC[i][31:16] * VEC[i][15:0];
                chk("R4 hi", t_out, prod[31:16]);
                chk("R4 lo", n_out, prod[15:0]);
            end
            chk("R7 ovf clear", ovf, 0);
            @(negedge clk);
            chk("R6 done pulse", done, 0);
        end

        // R2 single multiply steps
        launch(1'b0, 1'b1, 16'h0003, 16'h0005, 16'h0004);
        chk("R2 t add", t_out, 16'h0003); chk("R2 n add", n_out, 16'h8002);
        chk("R10 done", done, 1); chk("R10 busy", busy, 0);
        launch(1'b0, 1'b1, 16'h0005, 16'h0004, 16'h0004);
        chk("R2 t shift", t_out, 16'h0002); chk("R2 n shift", n_out, 16'h8002);
        // R3 single divide steps
        launch(1'b1, 1'b1, 16'h0003, 16'h8001, 16'h0005);
        chk("R3 t sub", t_out, 16'h0002); chk("R3 n sub", n_out, 16'h0003);
        launch(1'b1, 1'b1, 16'h0001, 16'h0000, 16'h0005);
        chk("R3 t keep", t_out, 16'h0002); chk("R3 n keep", n_out, 16'h0000);
        @(negedge clk);
        chk("R10 done pulse", done, 0);

        // R9 invalid opcode
        @(negedge clk);
        op_code = 5'b00011; single = 1'b0; t_in = 16'h1; n_in = 16'h2; n2_in = 16'h3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 t", t_out, 16'h0002); chk("R9 n", n_out, 16'h0000);
        chk("R9 busy/done", {busy, done}, 0);

        // R7 overflow set and held, then cleared
        launch(1'b1, 1'b0, 16'h0005, 16'h0000, 16'h0005);
        wait_end(cyc);
        chk("R7 ovf set", ovf, 1);
        repeat (3) @(negedge clk);
        chk("R7 ovf held", ovf, 1);
        launch(1'b0, 1'b0, 16'h0000, 16'd3, 16'd4);
        chk("R7 ovf cleared", ovf, 0);
        wait_end(cyc);

        // R8 start while busy ignored
        launch(1'b0, 1'b0, 16'h0000, 16'd11, 16'd13);
        repeat (2) @(negedge clk);
        op_code = 5'b11111; single = 1'b1; t_in = 16'h0009; n_in = 16'h0000; n2_in = 16'h0002; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end(cyc);
        chk("R8 busy len", cyc, 13);
        chk("R8 hi", t_out, 0); chk("R8 lo", n_out, 143);
        chk("R8 ovf", ovf, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule